// File: doc/BRIEF.md
# Two-Wire Configuration Register Write Slave

This block lets a host program a small bank of 9-bit configuration registers over a two-wire serial bus of the I2C kind. It only accepts writes. A fast system clock samples the bus clock and data lines. The block finds start and stop conditions and checks for a fixed 7-bit device address. It then takes in a 16-bit control word. That word carries a 7-bit register address and a 9-bit value. The block acknowledges each accepted byte by enabling an open-drain pull-down on the data line.

A finished write pulses a one-cycle strobe that carries the address and the data, and it updates the addressed register. A write to register address zero is a soft reset: every register goes back to its parameterised default. A start or stop that arrives in the middle of a frame abandons the partial write.

States: `ST_IDLE` (waiting for a start), `ST_DEVADR` (shifting the device byte), `ST_DEVACK`, `ST_REGHI` (register address and data bit 8), `ST_HIACK`, `ST_REGLO` (data bits 7..0), `ST_LOACK` (commit), and `ST_DONE` (ignore the bus until the next start or stop).

Transitions:
- A start goes from any state to `ST_DEVADR`.
- A stop goes from any state to `ST_IDLE`.
- Each shift state moves to its acknowledge state on the bus-clock fall that follows the eighth sampled bit. `ST_DEVADR` goes to `ST_IDLE` instead when the address is wrong or the request is a read.
- Each acknowledge state moves on at the next bus-clock fall: `ST_DEVACK` to `ST_REGHI`, `ST_HIACK` to `ST_REGLO`, and `ST_LOACK` to `ST_DONE`.

Top module: `twc_cfg_slave`

## Requirements
- R1: After reset, `reg_bank` holds the defaults. Register i sits at bits [9i+8:9i]. `sda_pull_low` and `wr_strobe` are 0.
- R2: A fall of the data line while the bus clock is high is a start. After a start, the block samples eight bits, MSB first, on rising bus-clock edges.
- R3: If the 8-bit device byte equals {7'b0011010, 1'b0}, the block asserts `sda_pull_low` through the ninth bus-clock pulse.
- R4: If the device address differs, or bit 0 (read/write) is 1, the block gives no acknowledge. It then ignores the rest of the frame and acknowledges nothing more until a new start.
- R5: The first data byte carries the register address in bits [7:1] and data bit 8 in bit 0. The second data byte carries data bits [7:0]. Both bytes are acknowledged.
- R6: When the second data byte's acknowledge begins, `wr_strobe` is high for exactly one cycle, with `wr_addr` and `wr_data` valid. The addressed register then takes the data. Addresses at or above the bank size change no register, and no register changes without a strobe.
- R7: A write of any value to register address 0 sets every register to its default.
- R8: A stop, or a fresh start, that arrives before the second data byte is complete discards the partial write, and no strobe is issued. A fresh start opens a new device-address phase.
- R9: `sda_pull_low` changes only while the synchronized bus clock is low.
- R10: After a completed write, further bytes in the same frame are not acknowledged and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line (wired level) |
| sda_pull_low | output | 1 | Open-drain enable: 1 pulls the data line low |
| wr_strobe | output | 1 | One-cycle pulse on a completed write |
| wr_addr | output | 7 | Register address of the completed write |
| wr_data | output | 9 | Data of the completed write |
| reg_bank | output | NUM_REGS*9 | Flattened register contents |

## Verification
Some properties are checked on every clock cycle:
- the acknowledge drive switches only while the bus clock is low;
- a rising acknowledge after the address phase implies a matching write address;
- the strobe lasts one cycle and falls inside an acknowledge;
- the bank never moves without a strobe;
- a write to register zero leaves the defaults in place.

Other behaviours only the bench scenarios can show: that the correct bits land in the correct register, that reads and foreign addresses are ignored for the whole frame, that a stop or restart part-way through throws the frame away, and that extra bytes after a completed write get no acknowledge.

// File: rtl/twc_pkg.sv
package twc_pkg;
    localparam int REGA_W = 7;
    localparam int DATA_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_REGHI,
        ST_HIACK,
        ST_REGLO,
        ST_LOACK,
        ST_DONE
    } twc_state_e;
endpackage

// File: rtl/twc_line_sync.sv
module twc_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic scl_prev;
    logic sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_in};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_in};
        end
    end

    assign scl_lvl  = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl  = sda_pipe[SYNC_STAGES-1];
    assign scl_prev = scl_pipe[SYNC_STAGES];
    assign sda_prev = sda_pipe[SYNC_STAGES];

    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/twc_frame_fsm.sv
module twc_frame_fsm
    import twc_pkg::*;
#(
    parameter logic [REGA_W-1:0] DEV_ADDR = 7'b0011010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_pull,
    output logic              wr_strobe,
    output logic [REGA_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    twc_state_e state, nxt;
    logic [7:0] shreg;
    logic [7:0] hi_q;
    logic [2:0] bitcnt;
    logic       byte_full;
    logic       shifting;

    assign shifting = (state == ST_DEVADR) || (state == ST_REGHI) || (state == ST_REGLO);

    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_DEVADR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   nxt = ST_IDLE;
                ST_DEVADR: if (scl_fall && byte_full)
                               nxt = (shreg == {DEV_ADDR, 1'b0}) ? ST_DEVACK : ST_IDLE;
                ST_DEVACK: if (scl_fall) nxt = ST_REGHI;
                ST_REGHI:  if (scl_fall && byte_full) nxt = ST_HIACK;
                ST_HIACK:  if (scl_fall) nxt = ST_REGLO;
                ST_REGLO:  if (scl_fall && byte_full) nxt = ST_LOACK;
                ST_LOACK:  if (scl_fall) nxt = ST_DONE;
                ST_DONE:   nxt = ST_DONE;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // state register and bit datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            hi_q      <= '0;
            bitcnt    <= '0;
            byte_full <= 1'b0;
        end else begin
            state <= nxt;
            if (start_det) begin
                bitcnt    <= '0;
                byte_full <= 1'b0;
            end else if (shifting && scl_rise) begin
                shreg     <= {shreg[6:0], sda_lvl};
                bitcnt    <= bitcnt + 3'd1;
                byte_full <= (bitcnt == 3'd7);
            end else if (scl_fall) begin
                byte_full <= 1'b0;
            end
            if (state == ST_REGHI && nxt == ST_HIACK)
                hi_q <= shreg;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_strobe <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_strobe <= (state == ST_REGLO) && (nxt == ST_LOACK);
            if ((state == ST_REGLO) && (nxt == ST_LOACK)) begin
                wr_addr <= hi_q[7:1];
                wr_data <= {hi_q[0], shreg};
            end
        end
    end

    assign sda_pull = (state == ST_DEVACK) || (state == ST_HIACK) || (state == ST_LOACK);

    assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_lvl);
    assert_ack_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_pull) && $past(state == ST_DEVADR)) |-> ($past(shreg) == {DEV_ADDR, 1'b0}));
    assert_strobe_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);
    assert_strobe_in_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> sda_pull);
endmodule

// File: rtl/twc_reg_bank.sv
module twc_reg_bank
    import twc_pkg::*;
#(
    parameter int                         NUM_REGS     = 8,
    parameter logic [NUM_REGS*DATA_W-1:0] REG_DEFAULTS = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_strobe,
    input  logic [REGA_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NUM_REGS*DATA_W-1:0]   bank_flat
);
    logic soft_rst;
    assign soft_rst = wr_strobe && (wr_addr == '0);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [DATA_W-1:0] value;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                value <= REG_DEFAULTS[i*DATA_W +: DATA_W];
            else if (soft_rst)
                value <= REG_DEFAULTS[i*DATA_W +: DATA_W];
            else if (wr_strobe && wr_addr == REGA_W'(i))
                value <= wr_data;
        end
        assign bank_flat[i*DATA_W +: DATA_W] = value;
    end

    assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && wr_addr == '0) |=> (bank_flat == REG_DEFAULTS));
    assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe |=> $stable(bank_flat));
endmodule

// File: rtl/twc_cfg_slave.sv
module twc_cfg_slave
    import twc_pkg::*;
#(
    parameter logic [REGA_W-1:0]          DEV_ADDR     = 7'b0011010,
    parameter int                         NUM_REGS     = 8,
    parameter int                         SYNC_STAGES  = 2,
    parameter logic [NUM_REGS*DATA_W-1:0] REG_DEFAULTS =
        {9'h07E, 9'h100, 9'h050, 9'h1FF, 9'h001, 9'h13C, 9'h0A5, 9'h000}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_in,
    input  logic                       sda_in,
    output logic                       sda_pull_low,
    output logic                       wr_strobe,
    output logic [REGA_W-1:0]          wr_addr,
    output logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] reg_bank
);
    logic scl_lvl, scl_rise, scl_fall, sda_lvl, start_det, stop_det;

    twc_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det)
    );

    twc_frame_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .sda_lvl(sda_lvl), .start_det(start_det),
        .stop_det(stop_det), .sda_pull(sda_pull_low), .wr_strobe(wr_strobe),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    twc_reg_bank #(.NUM_REGS(NUM_REGS), .REG_DEFAULTS(REG_DEFAULTS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
        .wr_data(wr_data), .bank_flat(reg_bank)
    );
endmodule

// File: tb/tb_twc_cfg_slave.sv
module tb_twc_cfg_slave;
    localparam int NREG = 8;
    localparam int H = 8;
    localparam logic [NREG*9-1:0] DEFS =
        {9'h07E, 9'h100, 9'h050, 9'h1FF, 9'h001, 9'h13C, 9'h0A5, 9'h000};
    // {device byte, register address, data}
    localparam logic [23:0] VECS [7] = '{
        {8'h34, 7'd1,  9'h1C3},
        {8'h34, 7'd7,  9'h055},
        {8'h36, 7'd2,  9'h0FF},
        {8'h35, 7'd3,  9'h0F0},
        {8'h34, 7'd3,  9'h100},
        {8'h34, 7'h45, 9'h1AA},
        {8'h34, 7'd0,  9'h000}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic scl_m = 1;
    logic sda_m = 1;
    logic sda_pull_low, wr_strobe;
    logic [6:0] wr_addr;
    logic [8:0] wr_data;
    logic [NREG*9-1:0] reg_bank;
    logic sda_line;

    int errors = 0;
    int checks = 0;
    int strobes = 0;
    logic [6:0] last_addr;
    logic [8:0] last_data;
    logic [NREG*9-1:0] model;
    bit done = 0;

    assign sda_line = sda_m & ~sda_pull_low;

    always #5 clk = ~clk;

    twc_cfg_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull_low(sda_pull_low), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
        .wr_data(wr_data), .reg_bank(reg_bank)
    );

    always @(posedge clk) if (wr_strobe) begin
        strobes   <= strobes + 1;
        last_addr <= wr_addr;
        last_data <= wr_data;
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1; waitc(H); scl_m = 1; waitc(H); sda_m = 0; waitc(H); scl_m = 0; waitc(H);
    endtask

    task automatic bus_stop;
        sda_m = 0; waitc(H); scl_m = 1; waitc(H); sda_m = 1; waitc(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; waitc(H); scl_m = 1; waitc(H); scl_m = 0; waitc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1; waitc(H); scl_m = 1; waitc(H / 2);
        acked = ~sda_line;
        waitc(H / 2); scl_m = 0; waitc(H);
    endtask

    task automatic apply_model(input logic [6:0] ra, input logic [8:0] d);
        if (ra == 7'd0) model = DEFS;
        else if (ra < NREG) model[ra*9 +: 9] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic a0, a1, a2;
        int s0;
        model = DEFS;
        waitc(4); rst_n = 1; waitc(4);
        // R1 reset state
        check(reg_bank == DEFS, "R1 bank defaults", reg_bank, DEFS);
        check(sda_pull_low == 0, "R1 no pull", sda_pull_low, 0);
        check(wr_strobe == 0, "R1 no strobe", wr_strobe, 0);

        // table walk: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < 7; v++) begin
            logic [7:0] dev;
            logic [6:0] ra;
            logic [8:0] d;
            bit exp_ack;
            dev = VECS[v][23:16]; ra = VECS[v][15:9]; d = VECS[v][8:0];
            exp_ack = (dev == 8'h34);
            s0 = strobes;
            bus_start;
            send_byte(dev, a0);
            check(a0 == exp_ack, "R3/R4 device ack", a0, exp_ack);
            send_byte({ra, d[8]}, a1);
            check(a1 == exp_ack, "R5/R4 first byte ack", a1, exp_ack);
            if (exp_ack) begin
                send_byte(d[7:0], a2);
                check(a2 == 1, "R5 second byte ack", a2, 1);
                check(last_addr == ra && last_data == d, "R6 strobe payload",
                      {last_addr, last_data}, {ra, d});
                apply_model(ra, d);
            end
            bus_stop;
            check(strobes - s0 == (exp_ack ? 1 : 0), "R6/R4 strobe count", strobes - s0, exp_ack);
            check(reg_bank == model, (ra == 0) ? "R7 soft reset bank" : "R6 bank contents", reg_bank, model);
        end

        // R8: stop inside second byte discards
        s0 = strobes;
        bus_start; send_byte(8'h34, a0); send_byte({7'd6, 1'b1}, a1);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop;
        check(strobes == s0 && reg_bank == model, "R8 stop abort", reg_bank, model);

        // R8: restart inside second byte discards, new frame proceeds
        s0 = strobes;
        bus_start; send_byte(8'h34, a0); send_byte({7'd4, 1'b0}, a1);
        for (int i = 0; i < 3; i++) put_bit(1'b0);
        bus_start; send_byte(8'h34, a0);
        check(a0 == 1, "R8 restart address ack", a0, 1);
        send_byte({7'd5, 1'b1}, a1); send_byte(8'h22, a2);
        bus_stop;
        apply_model(7'd5, 9'h122);
        check(strobes - s0 == 1, "R8 restart single strobe", strobes - s0, 1);
        check(reg_bank == model, "R8 restart bank", reg_bank, model);

        // R10: extra byte after completed write
        s0 = strobes;
        bus_start; send_byte(8'h34, a0); send_byte({7'd2, 1'b0}, a1); send_byte(8'h9C, a2);
        send_byte(8'hFF, a2);
        check(a2 == 0, "R10 extra byte not acked", a2, 0);
        bus_stop;
        apply_model(7'd2, 9'h09C);
        check(strobes - s0 == 1 && reg_bank == model, "R10 bank after extra byte", reg_bank, model);

        // R4: read request, trailing bytes ignored
        bus_start; send_byte(8'h35, a0); send_byte(8'h00, a1); send_byte(8'h00, a2);
        bus_stop;
        check(a0 == 0 && a1 == 0 && a2 == 0, "R4 read ignored", {a0, a1, a2}, 0);
        check(reg_bank == model, "R4 bank unchanged", reg_bank, model);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule